// File: doc/BRIEF.md
# GPIO Edge Trigger Status Unit

This block watches a small bank of general-purpose input pins and records which of them saw a qualifying transition. Each pin has its own settings: a GPIO enable, a direction, a rising-edge enable, a falling-edge enable and an SMI enable. Each pin input first passes through a two-flop synchronizer. An edge is detected by comparing the synchronized value with its value one clock earlier. A qualifying edge sets a sticky per-pin status bit. Software clears that bit by writing a one to it.

The status bits are masked by the SMI enables and then ORed into a single SMI request line. Software reaches the block through a simple 32-bit word-addressed register port. Writes take effect on the clock edge. Read data appears one cycle after the read strobe. The pin count is a parameter from 1 to 32, and the reset value of the GPIO enable register is also a parameter. The default configuration is a six-pin bank whose GPIO enables reset to all ones.

The reset input is expected to be asserted asynchronously and released in step with the clock. The pins should be held low, or at their idle level, while reset is released.

Top module: `gpio_edge_status`

## Requirements
- R1: With the pin configured as an input, its GPIO enable set and its rising-edge enable set, a low-to-high pin transition sets that pin's status bit.
- R2: With the pin configured as an input, its GPIO enable set and its falling-edge enable set, a high-to-low pin transition sets that pin's status bit.
- R3: With both edge enables set, either transition direction sets the status bit. With neither set, no transition sets it.
- R4: A pin whose direction bit is 1 (output) never sets its status bit, whatever its edge enables are.
- R5: A pin whose GPIO enable bit is 0 never sets its status bit.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: When a qualifying edge and a clearing write hit the same status bit on the same clock edge, the bit ends up set.
- R8: `smi_req` is high exactly when some status bit is set whose SMI enable bit is also set.
- R9: After reset, the GPIO enable register reads the parameter `EN_RESET` (default 6'h3F), all other registers read 0, and `smi_req` is low.
- R10: Register word addresses are: 0 GPIO enable, 1 direction, 2 rising-edge enable, 3 falling-edge enable, 4 SMI enable, 5 status. Addresses 6 and 7 read 0. Bits at and above `NPINS` read 0 and ignore writes.
- R11: `rdata` is valid in the cycle after `rd_en` is sampled. A pin change sampled at clock edge k is reflected in the status bit and in `smi_req` after edge k+2, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| pins_in | input | NPINS | Raw pin inputs |
| smi_req | output | 1 | Aggregated SMI request |

## Verification
The edge logic is swept over all sixteen combinations of GPIO enable, direction, rising enable and falling enable. Each combination is tried with a rising step and then a falling step. This separates the rising path from the falling path, and separates the output and disabled blocks from the edge enables themselves.

A mixed per-pin pattern, with different enables on neighbouring pins, shows that the bits do not leak into each other. SMI masks that overlap the status bits and masks that do not show the gating at work. A clearing write placed on exactly the cycle the status bit is set separates "set wins" from "clear wins". Cycle-by-cycle sampling of `smi_req` pins down the synchronizer depth.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    SEL_EN   = 3'd0,
    SEL_DIR  = 3'd1,
    SEL_RISE = 3'd2,
    SEL_FALL = 3'd3,
    SEL_SMI  = 3'd4,
    SEL_STAT = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] gpio_en,
  input  logic [W-1:0] is_out,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  // One qualifier per pin
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic up, down;
    assign up     = level[i] & ~prev_q[i];
    assign down   = ~level[i] & prev_q[i];
    assign hit[i] = gpio_en[i] & ~is_out[i] &
                    ((up & rise_en[i]) | (down & fall_en[i]));
  end
endmodule

// File: rtl/gpio_status_reg.sv
module gpio_status_reg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status
);
  logic [W-1:0] status_d;

  // A new event outranks a clear on the same edge
  always_comb status_d = (status & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_d;
  end
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status
  import gpio_evt_pkg::*;
#(
  parameter int               NPINS    = 6,
  parameter logic [NPINS-1:0] EN_RESET = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [NPINS-1:0]    pins_in,
  output logic                smi_req
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr);

  logic [NPINS-1:0] en_q, dir_q, rise_q, fall_q, smi_q;
  logic [NPINS-1:0] wbits, level, hit, clr, status_q;
  logic             ce_en, ce_dir, ce_rise, ce_fall, ce_smi;
  logic [DATA_W-1:0] rdata_d;

  assign wbits   = wdata[NPINS-1:0];
  assign ce_en   = wr_en && (sel == SEL_EN);
  assign ce_dir  = wr_en && (sel == SEL_DIR);
  assign ce_rise = wr_en && (sel == SEL_RISE);
  assign ce_fall = wr_en && (sel == SEL_FALL);
  assign ce_smi  = wr_en && (sel == SEL_SMI);
  assign clr     = (wr_en && (sel == SEL_STAT)) ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= EN_RESET;
      dir_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      smi_q  <= '0;
    end else begin
      if (ce_en)   en_q   <= wbits;
      if (ce_dir)  dir_q  <= wbits;
      if (ce_rise) rise_q <= wbits;
      if (ce_fall) fall_q <= wbits;
      if (ce_smi)  smi_q  <= wbits;
    end
  end

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_in), .q(level)
  );

  gpio_edge_det #(.W(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(level), .gpio_en(en_q),
    .is_out(dir_q), .rise_en(rise_q), .fall_en(fall_q), .hit(hit)
  );

  gpio_status_reg #(.W(NPINS)) u_stat (
    .clk(clk), .rst_n(rst_n), .set(hit), .clr(clr), .status(status_q)
  );

  assign smi_req = |(status_q & smi_q);

  always_comb begin
    rdata_d = '0;
    case (sel)
      SEL_EN:   rdata_d[NPINS-1:0] = en_q;
      SEL_DIR:  rdata_d[NPINS-1:0] = dir_q;
      SEL_RISE: rdata_d[NPINS-1:0] = rise_q;
      SEL_FALL: rdata_d[NPINS-1:0] = fall_q;
      SEL_SMI:  rdata_d[NPINS-1:0] = smi_q;
      SEL_STAT: rdata_d[NPINS-1:0] = status_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rdata_d;
  end
endmodule

// File: rtl/gpio_edge_status_chk.sv
module gpio_edge_status_chk #(
  parameter int NPINS = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       addr,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic             smi_req,
  input logic [NPINS-1:0] status,
  input logic [NPINS-1:0] dir,
  input logic [NPINS-1:0] en,
  input logic [NPINS-1:0] smi_en
);
  localparam logic [31:0] MASK = 32'hFFFF_FFFF >> (32 - NPINS);

  logic [NPINS-1:0] wr_clr;
  assign wr_clr = (wr_en && addr == 3'd5) ? wdata[NPINS-1:0] : '0;

  // R10: unimplemented bits read zero
  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~MASK) == 32'd0);

  // R8: no request without an enabled status bit
  assert_smi_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_en == '0 || status == '0) |-> !smi_req);

  // R4: newly set bits never belong to output pins
  assert_no_out_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) & $past(dir)) == '0);

  // R5: newly set bits never belong to disabled pins
  assert_no_dis_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) & ~$past(en)) == '0);

  // R6: a bit drops only when a one was written to it
  assert_w1c_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status) & ~status) & ~$past(wr_clr)) == '0);
endmodule

bind gpio_edge_status gpio_edge_status_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .smi_req(smi_req), .status(status_q), .dir(dir_q),
  .en(en_q), .smi_en(smi_q)
);

// File: tb/gpio_edge_status_test.sv
module gpio_edge_status_test;
  localparam int N = 6;
  localparam logic [31:0] ALL = 32'h3F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] pins_in = '0;
  logic smi_req;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_edge_status uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pins_in(pins_in), .smi_req(smi_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    rd(3'd0, v); check("R9 en reset", v, ALL);
    for (int a = 1; a < 6; a++) begin
      rd(3'(a), v); check("R9 reg reset", v, 0);
    end
    check("R9 smi reset", {31'd0, smi_req}, 0);

    // R10 upper bits and unmapped addresses
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); check("R10 upper bits", v, ALL);
    wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, v); check("R10 addr6", v, 0);
    rd(3'd7, v); check("R10 addr7", v, 0);

    // Exhaustive sweep of per-pin config, same on all pins
    for (int cfg = 0; cfg < 16; cfg++) begin
      logic e, d, r, f;
      string tag;
      e = cfg[0]; d = cfg[1]; r = cfg[2]; f = cfg[3];
      tag = d ? "R4" : !e ? "R5" : (r && f) ? "R3" : r ? "R1" : f ? "R2" : "R3";
      wr(3'd0, e ? ALL : 0); wr(3'd1, d ? ALL : 0);
      wr(3'd2, r ? ALL : 0); wr(3'd3, f ? ALL : 0);
      wr(3'd5, ALL);
      pins_in = '1; settle();
      rd(3'd5, v); check({tag, " rise"}, v, (e && !d && r) ? ALL : 0);
      wr(3'd5, ALL);
      pins_in = '0; settle();
      rd(3'd5, v); check({tag, " fall"}, v, (e && !d && f) ? ALL : 0);
      wr(3'd5, ALL);
    end

    // Mixed per-pin pattern
    wr(3'd0, ALL); wr(3'd1, 32'h20); wr(3'd2, 32'h15); wr(3'd3, 32'h0C);
    pins_in = '1; settle();
    rd(3'd5, v); check("R1 R4 mixed rise", v, 32'h15);

    // R8 SMI gating
    wr(3'd4, 0);     check("R8 smi off", {31'd0, smi_req}, 0);
    wr(3'd4, 32'h2A); check("R8 smi disjoint", {31'd0, smi_req}, 0);
    wr(3'd4, 32'h04); check("R8 smi overlap", {31'd0, smi_req}, 1);

    // R6 write-one-to-clear
    wr(3'd5, 0);    rd(3'd5, v); check("R6 zero write", v, 32'h15);
    wr(3'd5, 1);    rd(3'd5, v); check("R6 clear one", v, 32'h14);
    check("R8 smi still", {31'd0, smi_req}, 1);
    wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, v); check("R6 clear all", v, 0);
    check("R8 smi dropped", {31'd0, smi_req}, 0);

    pins_in = '0; settle();
    rd(3'd5, v); check("R2 mixed fall", v, 32'h0C);

    // R7 set and clear on the same edge
    pins_in = '1;
    @(negedge clk); @(negedge clk);
    wr(3'd5, 32'h0C);
    settle();
    rd(3'd5, v); check("R7 set wins", v, 32'h15);

    // R11 edge latency through smi_req
    wr(3'd1, 0); wr(3'd2, ALL); wr(3'd4, 1);
    pins_in = '0; settle(); wr(3'd5, ALL);
    check("R11 idle", {31'd0, smi_req}, 0);
    pins_in = 6'h01;
    @(negedge clk); check("R11 after k", {31'd0, smi_req}, 0);
    @(negedge clk); check("R11 after k+1", {31'd0, smi_req}, 0);
    @(negedge clk); check("R11 after k+2", {31'd0, smi_req}, 1);

    // R11 read latency: rdata changes only after the read strobe
    rd_en = 1'b1; addr = 3'd0; @(negedge clk);
    addr = 3'd1; rd_en = 1'b0; @(negedge clk);
    check("R11 read hold", rdata, ALL);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule